// File: doc/BRIEF.md
# Strip-pair stub coincidence finder

This block looks at one bunch crossing of binary strip hits from two closely stacked strip sensors, an inner layer and an outer layer of 127 strips each. It sorts out hit pairs that come from stiff, high-momentum tracks. First, every one of the 254 channels can be silenced by its own mask bit. Then the surviving hits on each layer are grouped into one-dimensional clusters, and any cluster wider than a programmable limit is dropped.

Each inner cluster that remains is tested against the outer clusters that remain. It becomes a stub when an outer cluster centre lies inside a window around the inner centre. The window has a programmable half-width, and its centre can be moved by a signed offset to make up for the geometric shift between the layers. The block puts out a 127-bit stub map indexed by inner strip. It also gives two summary flags: one for any unmasked hit on the chip and one for any stub. Configuration comes in as static register values.

Top module: `stub_finder`

## Requirements
- R1: While reset is high and on the cycles after it, until a crossing has passed through, `stub_out`, `any_hit` and `any_stub` are all zero.
- R2: A mask bit of 1 forces its channel to "no hit". `mask_inner[i]` masks inner strip i and `mask_outer[i]` masks outer strip i, so a masked channel can neither form nor widen a cluster.
- R3: A cluster is a maximal run of adjacent hit strips on one layer. It is represented by the strip `start + floor((len-1)/2)`, which is the lower middle strip when the length is even.
- R4: A cluster is kept only if its length is at most `max_width` (3-bit, 0..7). A value of 0 discards every cluster.
- R5: `stub_out[i]` is 1 exactly when a kept inner cluster is centred at i and some kept outer cluster centre j satisfies `off - hw <= j - i <= off + hw`. Here `hw` is `half_win` (unsigned, 0..15) and `off` is `win_offset` (two's complement, -8..7).
- R6: The window is clipped to strips 0..126 and never wraps around the edges of the strip range.
- R7: `any_hit` is the OR of all 254 masked hits of a crossing and appears in the same cycle as that crossing's stub map.
- R8: `any_stub` is the OR of the 127 bits of `stub_out` in the same cycle.
- R9: Hits and masks are sampled on one rising edge, and the results for that crossing appear after the next rising edge. This is a latency of 2 cycles from the input set-up; after only one edge the outputs still show the previous crossing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst | input | 1 | Synchronous active-high reset |
| hit_inner | input | 127 | Inner-layer strip hits, bit i = strip i |
| hit_outer | input | 127 | Outer-layer strip hits, bit i = strip i |
| mask_inner | input | 127 | Inner-layer channel masks, 1 = disabled |
| mask_outer | input | 127 | Outer-layer channel masks, 1 = disabled |
| max_width | input | 3 | Largest accepted cluster length |
| half_win | input | 4 | Coincidence window half-width in strips |
| win_offset | input | 4 | Signed shift of the window centre |
| stub_out | output | 127 | Stub map, bit i set for inner centre strip i |
| any_hit | output | 1 | Any unmasked hit in the crossing |
| any_stub | output | 1 | Any stub in the crossing |

## Verification
The hardest cases to reach are the ones where several rules combine. One is a cluster whose length sits exactly at the width limit while its centre lies exactly on a window edge. Another is a window that has been pushed by a large offset past strip 0 or strip 126. Random hit maps almost never produce these. The bench therefore sweeps every combination of width limit, half-width and offset, each with a fresh hit map of moderate density. It adds directed maps that put clusters at the first and last strips, and it places an outer hit where a wrapped window would land.

// File: rtl/stub_pkg.sv
package stub_pkg;

    localparam int STRIPS   = 127;
    localparam int MW_BITS  = 3;
    localparam int HW_BITS  = 4;
    localparam int OFF_BITS = 4;

    // Two layers of one crossing travel together through the pipeline.
    typedef struct packed {
        logic [STRIPS-1:0] inner;
        logic [STRIPS-1:0] outer;
    } layer_pair_t;

    // Static coincidence settings.
    typedef struct packed {
        logic [MW_BITS-1:0]         max_width;
        logic [HW_BITS-1:0]         half_win;
        logic signed [OFF_BITS-1:0] offset;
    } coinc_cfg_t;

    // Is the signed strip distance d inside the shifted window?
    function automatic logic in_window(input int d, input int off, input int hw);
        return (d >= off - hw) && (d <= off + hw);
    endfunction

endpackage

// File: rtl/sf_cluster.sv
module sf_cluster #(
    parameter int N   = 127,
    parameter int MWB = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [N-1:0]   hit,
    input  logic [MWB-1:0] max_width,
    output logic [N-1:0]   centre
);
    // A run must be counted up to one beyond the widest legal cluster.
    localparam int SAT = 1 << MWB;
    localparam int CW  = MWB + 1;

    for (genvar i = 0; i < N; i++) begin : g_strip
        logic [CW-1:0] lcnt, rcnt;
        logic          lrun, rrun;
        logic [CW:0]   len;

        always_comb begin
            lcnt = '0;
            rcnt = '0;
            lrun = 1'b1;
            rrun = 1'b1;
            for (int k = 0; k < SAT; k++) begin
                if (lrun && (i - k) >= 0 && hit[((i - k) >= 0) ? (i - k) : 0])
                    lcnt = lcnt + CW'(1);
                else
                    lrun = 1'b0;
                if (rrun && (i + k) < N && hit[((i + k) < N) ? (i + k) : 0])
                    rcnt = rcnt + CW'(1);
                else
                    rrun = 1'b0;
            end
            len = {1'b0, lcnt} + {1'b0, rcnt} - (CW+1)'(1);
            // Centre = lower middle: right part equal to, or one longer than, left part.
            centre[i] = hit[i]
                      && ((rcnt == lcnt) || (rcnt == lcnt + CW'(1)))
                      && (len <= (CW+1)'(max_width));
        end
    end

    // R3: a centre marks a hit strip, and two centres are never adjacent.
    a_r3_centre_on_hit: assert property (@(posedge clk) disable iff (rst)
        (centre & ~hit) == '0);
    a_r3_no_adjacent: assert property (@(posedge clk) disable iff (rst)
        (centre & (centre >> 1)) == '0);
    // R4: a zero width limit keeps nothing.
    a_r4_zero_width: assert property (@(posedge clk) disable iff (rst)
        (max_width == '0) |-> (centre == '0));

endmodule

// File: rtl/sf_coinc.sv
module sf_coinc #(
    parameter int N    = 127,
    parameter int HWB  = 4,
    parameter int OFFB = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [N-1:0]           ci,
    input  logic [N-1:0]           co,
    input  logic [HWB-1:0]         half_win,
    input  logic signed [OFFB-1:0] offset,
    output logic [N-1:0]           stub
);
    import stub_pkg::*;

    localparam int HW_MAX  = (1 << HWB) - 1;
    localparam int OFF_MIN = -(1 << (OFFB - 1));
    localparam int OFF_MAX = (1 << (OFFB - 1)) - 1;
    localparam int D_LO    = OFF_MIN - HW_MAX;
    localparam int D_HI    = OFF_MAX + HW_MAX;

    int hw_i, off_i;
    always_comb begin
        hw_i  = int'(half_win);
        off_i = int'(offset);
    end

    for (genvar i = 0; i < N; i++) begin : g_strip
        logic match;
        always_comb begin
            match = 1'b0;
            for (int d = D_LO; d <= D_HI; d++) begin
                if ((i + d) >= 0 && (i + d) < N) begin
                    if (in_window(d, off_i, hw_i)
                        && co[((i + d) >= 0 && (i + d) < N) ? (i + d) : 0])
                        match = 1'b1;
                end
            end
            stub[i] = ci[i] & match;
        end
    end

    // R5: a stub is only raised on an inner cluster centre.
    a_r5_stub_on_centre: assert property (@(posedge clk) disable iff (rst)
        (stub & ~ci) == '0);
    // R5: no outer cluster anywhere means no stub anywhere.
    a_r5_needs_outer: assert property (@(posedge clk) disable iff (rst)
        (co == '0) |-> (stub == '0));

endmodule

// File: rtl/stub_finder.sv
module stub_finder
    import stub_pkg::*;
#(
    parameter int N = STRIPS
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [N-1:0]               hit_inner,
    input  logic [N-1:0]               hit_outer,
    input  logic [N-1:0]               mask_inner,
    input  logic [N-1:0]               mask_outer,
    input  logic [MW_BITS-1:0]         max_width,
    input  logic [HW_BITS-1:0]         half_win,
    input  logic signed [OFF_BITS-1:0] win_offset,
    output logic [N-1:0]               stub_out,
    output logic                       any_hit,
    output logic                       any_stub
);
    typedef struct packed {
        logic [N-1:0] inner;
        logic [N-1:0] outer;
    } pair_t;

    coinc_cfg_t cfg;
    pair_t      hit_q;
    pair_t      centre;
    logic [N-1:0] stub_c;

    always_comb begin
        cfg.max_width = max_width;
        cfg.half_win  = half_win;
        cfg.offset    = win_offset;
    end

    // Stage 1: sample and mask the crossing.
    always_ff @(posedge clk) begin
        if (rst) begin
            hit_q <= '0;
        end else begin
            hit_q.inner <= hit_inner & ~mask_inner;
            hit_q.outer <= hit_outer & ~mask_outer;
        end
    end

    sf_cluster #(.N(N), .MWB(MW_BITS)) u_clu_inner (
        .clk(clk), .rst(rst), .hit(hit_q.inner),
        .max_width(cfg.max_width), .centre(centre.inner)
    );

    sf_cluster #(.N(N), .MWB(MW_BITS)) u_clu_outer (
        .clk(clk), .rst(rst), .hit(hit_q.outer),
        .max_width(cfg.max_width), .centre(centre.outer)
    );

    sf_coinc #(.N(N), .HWB(HW_BITS), .OFFB(OFF_BITS)) u_coinc (
        .clk(clk), .rst(rst), .ci(centre.inner), .co(centre.outer),
        .half_win(cfg.half_win), .offset(cfg.offset), .stub(stub_c)
    );

    // Stage 2: results and summary flags.
    always_ff @(posedge clk) begin
        if (rst) begin
            stub_out <= '0;
            any_hit  <= 1'b0;
            any_stub <= 1'b0;
        end else begin
            stub_out <= stub_c;
            any_hit  <= |{hit_q.inner, hit_q.outer};
            any_stub <= |stub_c;
        end
    end

    // R2: a channel masked in the sampled cycle never reaches the cluster stage.
    a_r2_mask_inner: assert property (@(posedge clk) disable iff (rst)
        (hit_q.inner & $past(mask_inner)) == '0);
    a_r2_mask_outer: assert property (@(posedge clk) disable iff (rst)
        (hit_q.outer & $past(mask_outer)) == '0);
    // R8: the stub flag agrees with the stub map.
    a_r8_flag_matches: assert property (@(posedge clk) disable iff (rst)
        any_stub == (stub_out != '0));
    // R7: a stub cannot exist without activity.
    a_r7_stub_needs_hit: assert property (@(posedge clk) disable iff (rst)
        any_stub |-> any_hit);

endmodule

// File: tb/stub_finder_test.sv
module stub_finder_test;
    localparam int N = 127;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] hit_inner = '0, hit_outer = '0, mask_inner = '0, mask_outer = '0;
    logic [2:0]   max_width = 3'd0;
    logic [3:0]   half_win = 4'd0;
    logic [3:0]   win_offset = 4'd0;
    logic [N-1:0] stub_out;
    logic         any_hit, any_stub;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    stub_finder uut (
        .clk(clk), .rst(rst),
        .hit_inner(hit_inner), .hit_outer(hit_outer),
        .mask_inner(mask_inner), .mask_outer(mask_outer),
        .max_width(max_width), .half_win(half_win),
        .win_offset(win_offset),
        .stub_out(stub_out), .any_hit(any_hit), .any_stub(any_stub)
    );

    // Cluster centres of a masked layer, by scanning runs.
    function automatic logic [N-1:0] ref_centres(input logic [N-1:0] h, input int mw);
        logic [N-1:0] c = '0;
        int i = 0;
        while (i < N) begin
            if (h[i]) begin
                int s = i;
                int len;
                while (i < N && h[i]) i++;
                len = i - s;
                if (len <= mw) c[s + (len - 1) / 2] = 1'b1;
            end else begin
                i++;
            end
        end
        return c;
    endfunction

    function automatic logic [N-1:0] ref_stubs(input logic [N-1:0] hi, input logic [N-1:0] ho,
                                               input logic [N-1:0] mi, input logic [N-1:0] mo,
                                               input int mw, input int hw, input int off);
        logic [N-1:0] ci = ref_centres(hi & ~mi, mw);
        logic [N-1:0] co = ref_centres(ho & ~mo, mw);
        logic [N-1:0] s = '0;
        for (int i = 0; i < N; i++)
            if (ci[i])
                for (int j = i + off - hw; j <= i + off + hw; j++)
                    if (j >= 0 && j < N && co[j]) s[i] = 1'b1;
        return s;
    endfunction

    task automatic chk(input string req, input logic [N-1:0] got, input logic [N-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    // Apply one crossing, wait the two-edge latency, compare all outputs.
    task automatic run(input string req, input logic [N-1:0] hi, input logic [N-1:0] ho,
                       input logic [N-1:0] mi, input logic [N-1:0] mo,
                       input int mw, input int hw, input int off);
        logic [N-1:0] e;
        @(negedge clk);
        hit_inner = hi; hit_outer = ho; mask_inner = mi; mask_outer = mo;
        max_width = 3'(mw); half_win = 4'(hw); win_offset = 4'(off);
        e = ref_stubs(hi, ho, mi, mo, mw, hw, off);
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        chk({req, " stubs"}, stub_out, e);
        chk({req, " R7 any_hit"}, N'(any_hit), N'(|{hi & ~mi, ho & ~mo}));
        chk({req, " R8 any_stub"}, N'(any_stub), N'(e != '0));
    endtask

    function automatic logic [N-1:0] rnd(input int dens);
        logic [N-1:0] v;
        for (int i = 0; i < N; i++) v[i] = (($urandom % 8) < dens);
        return v;
    endfunction

    initial begin : watchdog
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [N-1:0] a, b, prev;
        // R1: outputs cleared under reset.
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset stubs", stub_out, '0);
        chk("R1 reset flags", N'({any_hit, any_stub}), '0);
        hit_inner = '1; hit_outer = '1; max_width = 3'd7;
        @(posedge clk); @(negedge clk);
        chk("R1 held in reset", N'({any_hit, any_stub}), '0);
        rst = 1'b0;
        hit_inner = '0; hit_outer = '0;

        // R3: single strips, even and odd cluster lengths.
        run("R3 single", N'(1) << 40, N'(1) << 40, '0, '0, 1, 0, 0);
        run("R3 even len", N'(3) << 40, N'(1) << 40, '0, '0, 2, 0, 0);
        run("R3 even lower", N'(3) << 40, N'(1) << 41, '0, '0, 2, 0, 0);
        run("R3 odd len", N'(7) << 40, N'(1) << 41, '0, '0, 3, 0, 0);
        run("R3 len four", N'(15) << 40, N'(1) << 41, '0, '0, 4, 0, 0);
        // R4: width limit edge and zero limit.
        run("R4 at limit", N'(31) << 50, N'(31) << 50, '0, '0, 5, 0, 0);
        run("R4 over limit", N'(63) << 50, N'(1) << 52, '0, '0, 5, 3, 0);
        run("R4 zero", N'(1) << 10, N'(1) << 10, '0, '0, 0, 3, 0);
        run("R4 wide seven", N'(127) << 60, N'(255) << 60, '0, '0, 7, 5, 0);
        // R2: mask splits a wide cluster into two accepted ones.
        run("R2 mask splits", N'(127) << 20, N'(1) << 21, N'(1) << 23, '0, 3, 0, 0);
        run("R2 mask outer", N'(1) << 30, N'(1) << 30, '0, N'(1) << 30, 7, 2, 0);
        run("R2 all masked", '1, '1, '1, '1, 7, 15, 0);
        // R5/R6: window edges and clipping without wrap.
        run("R5 edge hi", N'(1) << 30, N'(1) << 36, '0, '0, 1, 3, 3);
        run("R5 past edge", N'(1) << 30, N'(1) << 37, '0, '0, 1, 3, 3);
        run("R5 neg offset", N'(1) << 30, N'(1) << 19, '0, '0, 1, 3, -8);
        run("R6 top no wrap", N'(1) << 126, N'(1) << 6, '0, '0, 1, 0, 7);
        run("R6 bottom no wrap", N'(1), N'(1) << 120, '0, '0, 1, 0, -7);
        run("R6 strip 0", N'(1), N'(1) << 2, '0, '0, 1, 2, 0);
        run("R6 strip 126", N'(1) << 126, N'(1) << 126, '0, '0, 1, 15, -8);

        // R9: after one edge the previous crossing is still shown.
        a = N'(1) << 70;
        prev = stub_out;
        @(negedge clk);
        hit_inner = a; hit_outer = a; mask_inner = '0; mask_outer = '0;
        max_width = 3'd1; half_win = 4'd0; win_offset = 4'd0;
        @(posedge clk); @(negedge clk);
        chk("R9 one edge", stub_out, prev);
        @(posedge clk); @(negedge clk);
        chk("R9 two edges", stub_out, a);

        // R5/R4: sweep every configuration with a fresh hit map.
        for (int mw = 0; mw < 8; mw++)
            for (int hw = 0; hw < 16; hw++)
                for (int off = -8; off < 8; off++) begin
                    a = rnd(2);
                    b = rnd(2);
                    run("R5 sweep", a, b, rnd(1), rnd(1), mw, hw, off);
                end

        // R2/R7: dense and sparse random crossings with masks.
        for (int k = 0; k < 200; k++)
            run("R2 random", rnd(k % 5), rnd((k + 2) % 5), rnd(k % 3), rnd(k % 2),
                int'($urandom % 8), int'($urandom % 16), int'($urandom % 16) - 8);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule